// File: doc/BRIEF.md
# Programmable Minimum-Width Input Filter

This block cleans up a single-bit signal that arrives with no timing relation to the system clock, so that internal logic can use it safely. The raw input first runs through a chain of flip-flops, all on the one system clock. The chain is deeper than the common two stages and its length is a parameter. A width qualifier follows the chain. It changes its output level only after the synchronized input has held a new level for a number of consecutive clocks. That number is held in a register that can be rewritten at run time, so glitch rejection can be retuned without changing the hardware.

Pulses shorter than the threshold disappear. A pulse that is very short at the raw input may also be missed by the synchronizer itself. The block accepts that loss and does not stretch pulses. A one-cycle strobe marks every accepted change of level.

Top module: `pulse_width_filter`

## Requirements
- R1: While `rst` is high at a clock edge, the block clears its state. After that edge `dout` is 0, `dout_edge` is 0, the synchronizer stages are 0 and the threshold equals `DEFAULT_THR` (default 4).
- R2: The raw input passes through `SYNC_STAGES` flip-flops (default 6) before it is qualified. A level on `din_async` therefore reaches the qualifier `SYNC_STAGES` clocks after it is sampled, and `dout` stays 0 for at least the first `SYNC_STAGES` clocks after reset.
- R3: When the synchronized input differs from `dout` at `thr` consecutive clock edges, `dout` takes the new level at the `thr`-th of those edges. The path from `din_async` to `dout` is then `SYNC_STAGES + thr` clocks long.
- R4: If the synchronized input returns to the level of `dout` before `thr` edges have passed, the pulse is rejected. `dout` does not change, and the next difference starts counting again from zero.
- R5: A threshold of 0 behaves exactly like a threshold of 1. In both cases `dout` follows the synchronized input with one clock of latency, so a single-clock pulse is passed through.
- R6: When `thr_wr_en` is high at a clock edge, `thr_wr_data` becomes the threshold. The new value governs qualification from the next edge on.
- R7: An edge with `thr_wr_en` high clears the qualification count, and `dout` does not change at that edge. A partially qualified level is then judged against the new threshold from the beginning.
- R8: `dout_edge` is high for exactly the clock cycles in which `dout` has just changed level, and it is low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| din_async | input | 1 | Raw input, asynchronous to `clk` |
| thr_wr_en | input | 1 | Load strobe for the threshold register |
| thr_wr_data | input | CNT_W | New minimum width in clocks |
| dout | output | 1 | Filtered, registered level |
| dout_edge | output | 1 | One-cycle pulse when `dout` changes |

## Verification
The hardest case to reach is a threshold write that arrives while a new level is partly qualified. To hit it, the bench has to count the synchronizer delay so that the write lands in the middle of the count rather than before or after it. The stimulus holds a changed level for a few clocks past the chain delay, writes a larger threshold, and then checks that the output takes the full new width to change. Pulses one clock shorter than the threshold and pulses exactly at it are also driven at several thresholds, and a pseudo-random noise run mixes both.

// File: rtl/pwf_pkg.sv
package pwf_pkg;

  // Registered result of the width qualifier
  typedef struct packed {
    logic level;
    logic edge_seen;
  } pwf_out_t;

  // A threshold of zero is treated as one
  function automatic logic [31:0] pwf_eff_thr(input logic [31:0] thr);
    return (thr == 32'd0) ? 32'd1 : thr;
  endfunction

endpackage

// File: rtl/pwf_sync_chain.sv
module pwf_sync_chain #(
  parameter int STAGES = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic d_in,
  output logic d_sync
);

  logic [STAGES-1:0] stg;

  initial begin
    assert (STAGES >= 2) else $error("STAGES must be at least 2");
  end

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stg[0] <= 1'b0;
          else     stg[0] <= d_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stg[g] <= 1'b0;
          else     stg[g] <= stg[g-1];
        end
      end
    end
  endgenerate

  assign d_sync = stg[STAGES-1];

  logic past_ok;
  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  AST_SYNC_LAST_STAGE_DELAYED: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> (stg[STAGES-1] == $past(stg[STAGES-2]))); // R2

endmodule

// File: rtl/pwf_thr_reg.sv
module pwf_thr_reg #(
  parameter int CNT_W       = 16,
  parameter int DEFAULT_THR = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] thr_eff,
  output logic             wr_seen
);

  logic [CNT_W-1:0] thr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      thr_q   <= CNT_W'(DEFAULT_THR);
      wr_seen <= 1'b0;
    end else begin
      wr_seen <= wr_en;
      if (wr_en) thr_q <= wr_data;
    end
  end

  assign thr_eff = CNT_W'(pwf_pkg::pwf_eff_thr(32'(thr_q)));

  AST_THR_LOADED: assert property (@(posedge clk) disable iff (rst)
    wr_seen |-> (thr_q == $past(wr_data))); // R6

endmodule

// File: rtl/pwf_width_qual.sv
module pwf_width_qual #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             s_in,
  input  logic [CNT_W-1:0] thr_eff,
  input  logic             clr,
  output pwf_pkg::pwf_out_t q_out
);

  localparam int NXT_W = CNT_W + 1;

  logic [CNT_W-1:0] cnt;
  logic             lvl;
  logic             stb;
  logic [NXT_W-1:0] cnt_nxt;
  logic             differ;
  logic             reached;

  assign differ  = (s_in != lvl);
  assign cnt_nxt = {1'b0, cnt} + NXT_W'(1);
  assign reached = (cnt_nxt >= {1'b0, thr_eff});

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      lvl <= 1'b0;
      stb <= 1'b0;
    end else begin
      stb <= 1'b0;
      if (clr || !differ) begin
        cnt <= '0;
      end else if (reached) begin
        cnt <= '0;
        lvl <= s_in;
        stb <= 1'b1;
      end else begin
        cnt <= cnt_nxt[CNT_W-1:0];
      end
    end
  end

  assign q_out.level     = lvl;
  assign q_out.edge_seen = stb;

  logic past_ok;
  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  AST_EDGE_MATCHES_FLIP: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> (stb == (lvl != $past(lvl)))); // R8
  AST_WRITE_CLEARS_COUNT: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(clr)) |-> (cnt == '0 && lvl == $past(lvl))); // R7
  AST_COUNT_BELOW_THR: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> (cnt < thr_eff)); // R3
  AST_FLIP_NEEDS_DIFF: assert property (@(posedge clk) disable iff (rst)
    (past_ok && stb) |-> ($past(s_in) != $past(lvl))); // R4

endmodule

// File: rtl/pulse_width_filter.sv
module pulse_width_filter #(
  parameter int SYNC_STAGES = 6,
  parameter int CNT_W       = 16,
  parameter int DEFAULT_THR = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             din_async,
  input  logic             thr_wr_en,
  input  logic [CNT_W-1:0] thr_wr_data,
  output logic             dout,
  output logic             dout_edge
);

  logic              s_sync;
  logic [CNT_W-1:0]  thr_eff;
  logic              wr_seen;
  pwf_pkg::pwf_out_t q_out;

  pwf_sync_chain #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .d_in   (din_async),
    .d_sync (s_sync)
  );

  pwf_thr_reg #(.CNT_W(CNT_W), .DEFAULT_THR(DEFAULT_THR)) u_thr (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (thr_wr_en),
    .wr_data (thr_wr_data),
    .thr_eff (thr_eff),
    .wr_seen (wr_seen)
  );

  pwf_width_qual #(.CNT_W(CNT_W)) u_qual (
    .clk     (clk),
    .rst     (rst),
    .s_in    (s_sync),
    .thr_eff (thr_eff),
    .clr     (thr_wr_en),
    .q_out   (q_out)
  );

  assign dout      = q_out.level;
  assign dout_edge = q_out.edge_seen;

  AST_WRITE_HOLDS_OUTPUT: assert property (@(posedge clk) disable iff (rst)
    wr_seen |-> !dout_edge); // R7

endmodule

// File: tb/tb_pulse_width_filter.sv
module tb_pulse_width_filter;

  localparam int N     = 6;
  localparam int W     = 16;
  localparam int DEFT  = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic din = 1'b0;
  logic wr_en = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic dout, dout_edge;

  int n_cmp = 0;
  int n_bad = 0;
  string phase = "R1";

  always #4 clk = ~clk;

  pulse_width_filter #(.SYNC_STAGES(N), .CNT_W(W), .DEFAULT_THR(DEFT)) dut (
    .clk(clk), .rst(rst), .din_async(din), .thr_wr_en(wr_en),
    .thr_wr_data(wr_data), .dout(dout), .dout_edge(dout_edge)
  );

  // Behavioural reference model
  logic q[$];
  int   m_cnt = 0;
  int   m_thr = DEFT;
  logic m_out = 1'b0;
  logic m_stb = 1'b0;

  always @(posedge clk) begin
    logic s;
    int   t;
    if (rst) begin
      q = {};
      for (int i = 0; i < N; i++) q.push_back(1'b0);
      m_cnt = 0; m_thr = DEFT; m_out = 1'b0; m_stb = 1'b0;
    end else begin
      s = q[N-1];
      t = (m_thr == 0) ? 1 : m_thr;
      m_stb = 1'b0;
      if (wr_en || s == m_out) m_cnt = 0;
      else if (m_cnt + 1 >= t) begin
        m_cnt = 0; m_out = s; m_stb = 1'b1;
      end else m_cnt = m_cnt + 1;
      if (wr_en) m_thr = int'(wr_data);
      q.push_front(din);
      void'(q.pop_back());
    end
  end

  // Compare on every falling edge, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      n_cmp++;
      if (dout !== m_out || dout_edge !== m_stb) begin
        n_bad++;
        $display("FAIL %s t=%0t dout/edge actual=%b/%b expected=%b/%b",
                 phase, $time, dout, dout_edge, m_out, m_stb);
      end
    end
  end

  task automatic hold(input logic v, input int n);
    din = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic write_thr(input int v);
    wr_en = 1'b1; wr_data = W'(v);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    logic [7:0] lfsr;
    repeat (3) @(negedge clk);
    // R1: reset state, checked while reset is held
    n_cmp++;
    if (dout !== 1'b0 || dout_edge !== 1'b0) begin
      n_bad++;
      $display("FAIL R1 reset actual=%b/%b expected=0/0", dout, dout_edge);
    end
    // R2: input high from release; output must wait for the chain
    din = 1'b1;
    rst = 1'b0;
    phase = "R2";
    repeat (N) @(negedge clk);
    n_cmp++;
    if (dout !== 1'b0) begin
      n_bad++;
      $display("FAIL R2 early output actual=%b expected=0", dout);
    end
    phase = "R3";
    hold(1'b1, 20);
    // R4: low pulses of width 1..3 rejected at threshold 4
    phase = "R4";
    for (int w = 1; w < 4; w++) begin hold(1'b0, w); hold(1'b1, 12); end
    // R3: width exactly at threshold accepted, and one above
    phase = "R3";
    hold(1'b0, 4); hold(1'b1, 14);
    hold(1'b0, 5); hold(1'b1, 14);
    // R5: threshold 1 and 0 pass single-clock pulses
    phase = "R5";
    write_thr(1);
    hold(1'b0, 1); hold(1'b1, 1); hold(1'b0, 2); hold(1'b1, 10);
    write_thr(0);
    hold(1'b0, 1); hold(1'b1, 3); hold(1'b0, 1); hold(1'b1, 10);
    // R6: larger threshold
    phase = "R6";
    write_thr(10);
    hold(1'b0, 9); hold(1'b1, 20);
    hold(1'b0, 10); hold(1'b1, 25);
    // R7: write lands mid-qualification
    phase = "R7";
    write_thr(5);
    hold(1'b0, N + 3);
    write_thr(8);
    hold(1'b0, 20);
    hold(1'b1, N + 4);
    write_thr(8);
    hold(1'b1, 20);
    // R8: pseudo-random noise at threshold 3
    phase = "R8";
    write_thr(3);
    lfsr = 8'hA5;
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      din = (lfsr[2:0] == 3'd0) ? ~din : din;
      @(negedge clk);
    end
    hold(1'b0, 20);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule